// File: doc/BRIEF.md
# Four-Beat Burst Word Address Generator

This block supplies the word address for a synchronous memory that serves data in bursts of four words. A burst begins when one of two address strobes captures the external address. One strobe comes from the processor side and counts only while the first chip enable is active. The other comes from the controller side and always counts. On the following cycles the lowest two address bits are produced internally. They step to the next beat on each cycle that the advance input is high, and they hold on any cycle where advance is low, which gives a wait state. The upper address bits stay as they were loaded.

The beat order is set by an order input. The linear order counts the low bits up modulo four. The interleaved order XORs the loaded low bits with a beat count that runs 0 to 3. A low level on the order input selects interleaved, so interleaved is the default when the pin is tied low. A strobe on any cycle replaces the current address. Bursting is therefore optional, and a fresh address can be taken every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is high, the address output reads zero in the cycle after each clock edge.
- R2: At a clock edge where `proc_strobe` and `chip_en` are both high, `addr_in` is loaded, and `word_addr` equals it after that edge.
- R3: At a clock edge where `proc_strobe` is high, `chip_en` is low and `ctrl_strobe` is low, nothing is loaded, and the edge acts as if no strobe were present (hold or advance).
- R4: At a clock edge where `ctrl_strobe` is high, `addr_in` is loaded whatever the value of `chip_en`. When both strobes are valid, the single address on `addr_in` is loaded once. The processor strobe is the selected source.
- R5: With `order_linear` = 1, each advancing edge raises the low two bits by one modulo 4. A load of low bits 1 gives 1,2,3,0.
- R6: With `order_linear` = 0 (interleaved, the default), the low two bits equal the loaded low bits XOR a beat count of 0,1,2,3. A load of 1 gives 1,0,3,2, and a load of 2 gives 2,3,0,1.
- R7: At a clock edge with no valid strobe and `advance` low, `word_addr` is unchanged.
- R8: Bits above the low two change only on a load. After the fourth beat, a further advance wraps back to the first beat address.
- R9: A valid strobe takes precedence over `advance`, so back-to-back loads on consecutive edges each show their own address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | First chip enable. When it is low, the processor strobe is ignored |
| proc_strobe | input | 1 | Processor-side burst start strobe |
| ctrl_strobe | input | 1 | Controller-side burst start strobe |
| advance | input | 1 | Step to the next beat on this edge |
| order_linear | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_in | input | ADDR_W | External word address to load |
| word_addr | output | ADDR_W | Current word address |

## Verification
The assertions assume that every input is a defined level at each rising edge. They also assume that `order_linear` does not change between a load and the next edge, because the low-bit mapping reads that pin combinationally. The bench changes inputs only one time unit after a rising edge. It changes the order input only on cycles where a load is applied, so the mapping stays constant between a load and the next edge.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;
    localparam int BEATS  = 1 << BEAT_W;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_PROC = 2'd1,
        SRC_CTRL = 2'd2
    } load_src_e;

    typedef enum logic {
        ORD_INTERLEAVED = 1'b0,
        ORD_LINEAR      = 1'b1
    } order_e;

    typedef struct packed {
        logic  load;
        logic  step;
    } ctl_t;

    // Beat address from loaded low bits and beat count, per order.
    function automatic beat_t map_beat(order_e ord, beat_t base, beat_t cnt);
        if (ord == ORD_LINEAR)
            return beat_t'(base + cnt);
        else
            return base ^ cnt;
    endfunction

endpackage

// File: rtl/burst_load_sel.sv
module burst_load_sel
    import burst_pkg::*;
(
    input  logic      chip_en,
    input  logic      proc_strobe,
    input  logic      ctrl_strobe,
    input  logic      advance,
    output load_src_e load_src,
    output ctl_t      ctl
);

    always_comb begin
        if (proc_strobe && chip_en)
            load_src = SRC_PROC;
        else if (ctrl_strobe)
            load_src = SRC_CTRL;
        else
            load_src = SRC_NONE;
    end

    always_comb begin
        ctl.load = (load_src != SRC_NONE);
        ctl.step = (load_src == SRC_NONE) && advance;
    end

endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
    import burst_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    output beat_t cnt
);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (ctl.load)
            cnt <= '0;
        else if (ctl.step)
            cnt <= beat_t'(cnt + 1'b1);
    end

    // R7: no load and no step keeps the beat count
    a_r7_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !ctl.step) |=> $stable(cnt));

    // R5: a step moves exactly one beat (wrapping, R8)
    a_r5_step_one: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && ctl.step) |=> (cnt == beat_t'($past(cnt) + 1'b1)));

    // R9: a load restarts at beat zero even when advance is high
    a_r9_load_restart: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (cnt == '0));

endmodule

// File: rtl/burst_addr_hold.sv
module burst_addr_hold
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] base_addr
);

    always_ff @(posedge clk) begin
        if (rst)
            base_addr <= '0;
        else if (ctl.load)
            base_addr <= addr_in;
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              proc_strobe,
    input  logic              ctrl_strobe,
    input  logic              advance,
    input  logic              order_linear,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int HI_W = ADDR_W - BEAT_W;

    load_src_e         load_src;
    ctl_t              ctl;
    beat_t             cnt;
    logic [ADDR_W-1:0] base_addr;
    order_e            ord;

    assign ord = order_e'(order_linear);

    burst_load_sel u_sel (
        .chip_en     (chip_en),
        .proc_strobe (proc_strobe),
        .ctrl_strobe (ctrl_strobe),
        .advance     (advance),
        .load_src    (load_src),
        .ctl         (ctl)
    );

    burst_beat_ctr u_ctr (
        .clk (clk),
        .rst (rst),
        .ctl (ctl),
        .cnt (cnt)
    );

    burst_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .addr_in   (addr_in),
        .base_addr (base_addr)
    );

    generate
        if (HI_W > 0) begin : g_upper
            assign word_addr[ADDR_W-1:BEAT_W] = base_addr[ADDR_W-1:BEAT_W];
        end
    endgenerate

    assign word_addr[BEAT_W-1:0] = map_beat(ord, base_addr[BEAT_W-1:0], cnt);

    // R2 / R4: a load shows the captured address on the next cycle
    a_r2_load_shows_addr: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (word_addr == $past(addr_in)));

    // R3: a processor strobe without chip enable and without the other strobe loads nothing
    a_r3_proc_gated: assert property (@(posedge clk) disable iff (rst)
        (proc_strobe && !chip_en && !ctrl_strobe) |-> !ctl.load);

    // R4: controller strobe always loads; processor wins when both are valid
    a_r4_ctrl_loads: assert property (@(posedge clk) disable iff (rst)
        ctrl_strobe |-> (ctl.load && (load_src == (proc_strobe && chip_en ? SRC_PROC : SRC_CTRL))));

    // R8: upper bits move only on a load
    a_r8_upper_stable: assert property (@(posedge clk) disable iff (rst)
        !ctl.load |=> $stable(word_addr[ADDR_W-1:BEAT_W]));

    // R7: wait state holds the whole address when the order pin is steady
    a_r7_wait_holds: assert property (@(posedge clk) disable iff (rst)
        (!ctl.load && !advance && $stable(order_linear)) |=> $stable(word_addr));

endmodule

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 18;
    localparam int WATCHDOG   = 5000;

    logic              clk = 1'b0;
    logic              rst;
    logic              chip_en;
    logic              proc_strobe;
    logic              ctrl_strobe;
    logic              advance;
    logic              order_linear;
    logic [ADDR_W-1:0] addr_in;
    logic [ADDR_W-1:0] word_addr;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .chip_en      (chip_en),
        .proc_strobe  (proc_strobe),
        .ctrl_strobe  (ctrl_strobe),
        .advance      (advance),
        .order_linear (order_linear),
        .addr_in      (addr_in),
        .word_addr    (word_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under %0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [ADDR_W-1:0] exp);
        n_checks++;
        if (word_addr !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, word_addr, exp);
        end
    endtask

    task automatic idle();
        chip_en = 1'b1; proc_strobe = 1'b0; ctrl_strobe = 1'b0; advance = 1'b0;
    endtask

    function automatic logic [1:0] exp_low(bit lin, logic [1:0] base, int k);
        logic [1:0] kk = 2'(k);
        return lin ? 2'(base + kk) : (base ^ kk);
    endfunction

    task automatic load_proc(logic [ADDR_W-1:0] a, bit lin);
        idle(); order_linear = lin; proc_strobe = 1'b1; addr_in = a;
        tick();
        idle();
    endtask

    task automatic t_reset();
        rst = 1'b1; idle(); order_linear = 1'b0; addr_in = 18'h2abcd; ctrl_strobe = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R1 reset", '0);
        end
        rst = 1'b0; idle();
    endtask

    task automatic t_proc_load();
        load_proc(18'h1234d, 1'b0);
        check("R2 proc load", 18'h1234d);
    endtask

    task automatic t_proc_ignored();
        load_proc(18'h05550, 1'b1);
        chip_en = 1'b0; proc_strobe = 1'b1; addr_in = 18'h3ffff;
        tick();
        check("R3 ignored proc strobe holds", 18'h05550);
        advance = 1'b1;
        tick();
        check("R3 ignored proc strobe advances", 18'h05551);
        idle();
    endtask

    task automatic t_ctrl_load();
        chip_en = 1'b0; ctrl_strobe = 1'b1; addr_in = 18'h2aaa6;
        tick();
        check("R4 ctrl load without chip enable", 18'h2aaa6);
        idle(); proc_strobe = 1'b1; ctrl_strobe = 1'b1; addr_in = 18'h01233;
        tick();
        check("R4 both strobes", 18'h01233);
        idle();
    endtask

    task automatic t_linear();
        logic [ADDR_W-1:0] a = 18'h3c0f1;
        load_proc(a, 1'b1);
        check("R5 linear beat 0", a);
        advance = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(k == 4 ? "R8 linear wrap" : "R5 linear beat",
                  {a[ADDR_W-1:2], exp_low(1'b1, a[1:0], k)});
        end
        idle();
    endtask

    task automatic t_interleave(logic [1:0] lo);
        logic [ADDR_W-1:0] a = {16'h9a5e, lo};
        load_proc(a, 1'b0);
        check("R6 interleaved beat 0", a);
        advance = 1'b1;
        for (int k = 1; k <= 4; k++) begin
            tick();
            check(k == 4 ? "R8 interleaved wrap" : "R6 interleaved beat",
                  {a[ADDR_W-1:2], exp_low(1'b0, lo, k)});
        end
        idle();
    endtask

    task automatic t_wait();
        logic [ADDR_W-1:0] a = 18'h12343;
        load_proc(a, 1'b0);
        advance = 1'b1;
        tick();
        check("R6 before wait", {a[ADDR_W-1:2], 2'd2});
        advance = 1'b0;
        tick();
        check("R7 wait state 1", {a[ADDR_W-1:2], 2'd2});
        tick();
        check("R7 wait state 2", {a[ADDR_W-1:2], 2'd2});
        advance = 1'b1;
        tick();
        check("R7 resume", {a[ADDR_W-1:2], 2'd1});
        idle();
    endtask

    task automatic t_back_to_back();
        logic [ADDR_W-1:0] seq [4] = '{18'h00011, 18'h3fffe, 18'h15553, 18'h2000c};
        for (int i = 0; i < 4; i++) begin
            idle(); advance = 1'b1; addr_in = seq[i];
            if (i % 2 == 0) proc_strobe = 1'b1; else begin chip_en = 1'b0; ctrl_strobe = 1'b1; end
            tick();
            check("R9 back to back load", seq[i]);
        end
        idle();
    endtask

    initial begin
        idle(); addr_in = '0; order_linear = 1'b0; rst = 1'b1;
        #1;
        t_reset();
        t_proc_load();
        t_proc_ignored();
        t_ctrl_load();
        t_linear();
        t_interleave(2'd1);
        t_interleave(2'd2);
        t_wait();
        t_back_to_back();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule